// File: doc/BRIEF.md
# Mode-Selectable Interrupt Line Router

This block sits between the board's interrupt sources and a shared 16-line interrupt bus on a processor tile. A 3-bit mode code decides two things for each bus line: whether the board drives it or listens to it, and which signal travels on it.

In legacy mode, the board drives only the per-CPU IRQ lines. When the FIQ variant is selected, it also drives the per-CPU FIQ lines. These lines are active-low and are taken from the outputs of four on-board interrupt controllers. In the same mode, the lower eight bus lines flow back from the processor as communication-channel receive and transmit flags.

In normal mode, the board drives all sixteen lines, active-high, into the processor's internal distributor. The lines carry twelve peripheral interrupts and the four controller outputs.

Any other code is either reserved or unsupported. For those codes the block drives nothing and leaves every line as an input. The mode code is captured while reset is held and stays frozen afterwards, so a change on the mode pins can never glitch a live interrupt line.

Top module: `irq_line_router`

## Requirements
- R1: The mode code is captured on every clock edge while `rst_n` is low. A change on `mode_code` while `rst_n` is high has no effect until the next reset.
- R2: While `rst_n` is low, and until the first rising edge with `rst_n` high, `tile_oe`, `tile_out`, `comm_rx` and `comm_tx` are all zero.
- R3: With captured code 010 (normal), `tile_oe` is all ones. `tile_out[9:0]` = `periph_irq[9:0]`, `tile_out[13:10]` = `ctrl_irq[3:0]` and `tile_out[15:14]` = `periph_irq[11:10]`, all active-high. The peripheral bit order is audio, timer 0/1, timer 2/3, USB, UART0, UART1, RTC, keyboard, mouse, Ethernet, card 0, card 1.
- R4: With captured code 000 or 100 (legacy), lines 8 and 9 are driven (`tile_oe` bit = 1). They carry CPU0 IRQ = NOT `ctrl_irq[0]` (controller 1) and CPU1 IRQ = NOT `ctrl_irq[2]` (controller 3), active-low.
- R5: With captured code 100, lines 12 and 13 are driven with CPU0 FIQ = NOT `ctrl_irq[1]` (controller 2) and CPU1 FIQ = NOT `ctrl_irq[3]` (controller 4). With code 000 these lines are not driven and output 0.
- R6: In legacy mode, lines 0 to 7, 10, 11, 14 and 15 are not driven and output 0.
- R7: In legacy mode, `comm_rx` = `tile_in[3:0]` and `comm_tx` = `tile_in[7:4]`. In every other state both flag outputs are zero.
- R8: With captured codes 001, 011, 101, 110 and 111, all of `tile_oe`, `tile_out`, `comm_rx` and `comm_tx` are zero.
- R9: Any line whose `tile_oe` bit is 0 has its `tile_out` bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode capture window |
| mode_code | input | 3 | Routing mode code |
| periph_irq | input | 12 | Peripheral interrupts, active-high, order as in R3 |
| ctrl_irq | input | 4 | Interrupt controller outputs 1 to 4, active-high |
| tile_in | input | 8 | Sensed level of bus lines 0 to 7 |
| tile_out | output | 16 | Value driven onto each bus line |
| tile_oe | output | 16 | Per-line drive enable, 1 = board drives |
| comm_rx | output | 4 | Comms receive flags from the processor |
| comm_tx | output | 4 | Comms transmit flags from the processor |

## Verification
The bench walks through all eight mode codes.

It first changes `mode_code` in the middle of operation. A design that sampled the code continuously would switch the line map on the spot and disagree with the frozen model.

It then checks the two legacy codes side by side. A design that ignored bit 2 would either drive the FIQ lines in plain legacy mode or leave them floating when the FIQ variant is selected.

It also checks the polarity of the legacy lines against random controller patterns, since a lost inversion shows up as a flipped IRQ level.

Finally, it checks the reserved and unsupported codes and the first cycle after reset release. Any leakage of drive enables there would put the board in contention with the processor.

// File: rtl/irq_route_pkg.sv
// Shared constants and mode decoding for the interrupt line router.
// Assumes a fixed 16-line tile bus whose line layout is set by the mode.
package irq_route_pkg;
    localparam int LINES   = 16;
    localparam int NPERIPH = 12;
    localparam int NCTRL   = 4;
    localparam int NCOMM   = 4;
    localparam int NSENSE  = 2 * NCOMM;

    typedef enum logic [1:0] {
        KIND_OFF    = 2'd0,
        KIND_LEGACY = 2'd1,
        KIND_NORMAL = 2'd2
    } route_kind_e;

    // Classify a 3-bit code: only 000/100 legacy and 010 normal are usable.
    function automatic route_kind_e classify(input logic [2:0] code);
        case (code)
            3'b000, 3'b100: classify = KIND_LEGACY;
            3'b010:         classify = KIND_NORMAL;
            default:        classify = KIND_OFF;
        endcase
    endfunction
endpackage

// File: rtl/irq_mode_reg.sv
// Holds the routing mode. Loads the pins only while reset is held, and
// raises a live flag on the first edge after release.
// Assumes rst_n is synchronous to clk.
module irq_mode_reg #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] mode_in,
    output logic [CODE_W-1:0] mode_q,
    output logic              live_q
);
    // Capture the mode during reset, hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_in;
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
        end
    end

    // R1: once live, the captured mode never moves until the next reset.
    p_mode_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |=> $stable(mode_q));
endmodule

// File: rtl/irq_legacy_map.sv
// Legacy routing: active-low per-CPU IRQ (and optionally FIQ) lines driven
// from controller outputs; lower lines sensed back as comms flags.
// Assumes ctrl[k] is controller k+1, active-high.
module irq_legacy_map
    import irq_route_pkg::*;
#(
    parameter int LN_IRQ0 = 8,
    parameter int LN_IRQ1 = 9,
    parameter int LN_FIQ0 = 12,
    parameter int LN_FIQ1 = 13
) (
    input  logic              fiq_en,
    input  logic [NCTRL-1:0]  ctrl,
    input  logic [NSENSE-1:0] sense,
    output logic [LINES-1:0]  out,
    output logic [LINES-1:0]  oe,
    output logic [NCOMM-1:0]  rx,
    output logic [NCOMM-1:0]  tx
);
    // Drive IRQ lines always and FIQ lines when enabled, inverted for active-low.
    always_comb begin
        out = '0;
        oe  = '0;
        oe[LN_IRQ0]  = 1'b1;
        out[LN_IRQ0] = ~ctrl[0];
        oe[LN_IRQ1]  = 1'b1;
        out[LN_IRQ1] = ~ctrl[2];
        if (fiq_en) begin
            oe[LN_FIQ0]  = 1'b1;
            out[LN_FIQ0] = ~ctrl[1];
            oe[LN_FIQ1]  = 1'b1;
            out[LN_FIQ1] = ~ctrl[3];
        end
    end

    // Split sensed lower lines into receive and transmit flag groups.
    for (genvar g = 0; g < NCOMM; g++) begin : g_comm
        assign rx[g] = sense[g];
        assign tx[g] = sense[NCOMM + g];
    end
endmodule

// File: rtl/irq_normal_map.sv
// Normal routing: peripheral and controller interrupts drive all sixteen
// lines, active-high. Assumes periph order audio..Ethernet then card 0/1.
module irq_normal_map
    import irq_route_pkg::*;
#(
    parameter int NLOW = 10
) (
    input  logic [NPERIPH-1:0] periph,
    input  logic [NCTRL-1:0]   ctrl,
    output logic [LINES-1:0]   out
);
    localparam int CTRL_BASE = NLOW;
    localparam int CARD_BASE = NLOW + NCTRL;

    // Place each source on its line index.
    for (genvar l = 0; l < LINES; l++) begin : g_line
        if (l < CTRL_BASE) begin : g_per
            assign out[l] = periph[l];
        end else if (l < CARD_BASE) begin : g_ctl
            assign out[l] = ctrl[l - CTRL_BASE];
        end else begin : g_card
            assign out[l] = periph[l - NCTRL];
        end
    end
endmodule

// File: rtl/irq_line_router.sv
// Top of the interrupt line router. Selects legacy, normal or quiet routing
// from the mode captured in reset; drives nothing until the first live cycle.
// Assumes synchronous active-low reset.
module irq_line_router
    import irq_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_code,
    input  logic [NPERIPH-1:0] periph_irq,
    input  logic [NCTRL-1:0]   ctrl_irq,
    input  logic [NSENSE-1:0]  tile_in,
    output logic [LINES-1:0]   tile_out,
    output logic [LINES-1:0]   tile_oe,
    output logic [NCOMM-1:0]   comm_rx,
    output logic [NCOMM-1:0]   comm_tx
);
    logic [2:0]       mode_q;
    logic             live_q;
    route_kind_e      kind;
    logic [LINES-1:0] leg_out, leg_oe, nrm_out;
    logic [NCOMM-1:0] leg_rx, leg_tx;

    irq_mode_reg #(.CODE_W(3)) i_mode (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_code),
        .mode_q(mode_q), .live_q(live_q)
    );

    irq_legacy_map i_leg (
        .fiq_en(mode_q[2]), .ctrl(ctrl_irq), .sense(tile_in),
        .out(leg_out), .oe(leg_oe), .rx(leg_rx), .tx(leg_tx)
    );

    irq_normal_map i_nrm (
        .periph(periph_irq), .ctrl(ctrl_irq), .out(nrm_out)
    );

    assign kind = classify(mode_q);

    // Pick the active mapping; quiet until live and for unusable codes.
    always_comb begin
        tile_out = '0;
        tile_oe  = '0;
        comm_rx  = '0;
        comm_tx  = '0;
        if (live_q) begin
            case (kind)
                KIND_LEGACY: begin
                    tile_out = leg_out;
                    tile_oe  = leg_oe;
                    comm_rx  = leg_rx;
                    comm_tx  = leg_tx;
                end
                KIND_NORMAL: begin
                    tile_out = nrm_out;
                    tile_oe  = '1;
                end
                default: ;
            endcase
        end
    end

    p_quiet_until_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q |-> (tile_oe == '0 && tile_out == '0 && comm_rx == '0 && comm_tx == '0));
    p_normal_drives_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && mode_q == 3'b010) |-> (tile_oe == '1));
    p_irq_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && mode_q[1:0] == 2'b00) |-> (tile_oe[9:8] == 2'b11 && tile_out[8] == !ctrl_irq[0]));
    p_fiq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && mode_q == 3'b000) |-> (tile_oe[13:12] == 2'b00));
    p_comm_legacy_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(live_q && mode_q[1:0] == 2'b00) |-> (comm_rx == '0 && comm_tx == '0));
    p_unusable_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && mode_q != 3'b000 && mode_q != 3'b100 && mode_q != 3'b010)
        |-> (tile_oe == '0 && tile_out == '0));
    p_undriven_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((tile_out & ~tile_oe) == '0));
endmodule

// File: tb/test_irq_line_router.sv
`timescale 1ns/1ps
module test_irq_line_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_code = 3'b010;
    logic [11:0] periph_irq = '0;
    logic [3:0]  ctrl_irq = '0;
    logic [7:0]  tile_in = '0;
    logic [15:0] tile_out, tile_oe;
    logic [3:0]  comm_rx, comm_tx;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit armed = 0;
    bit done = 0;
    int m_mode = 0;
    bit m_live = 0;

    always #2.5 clk = ~clk;

    irq_line_router i_irq_line_router (
        .clk(clk), .rst_n(rst_n), .mode_code(mode_code),
        .periph_irq(periph_irq), .ctrl_irq(ctrl_irq), .tile_in(tile_in),
        .tile_out(tile_out), .tile_oe(tile_oe), .comm_rx(comm_rx), .comm_tx(comm_tx)
    );

    // Behavioural model of the captured mode and live state.
    always @(posedge clk) begin
        armed <= 1'b1;
        cyc   <= cyc + 1;
        if (!rst_n) begin
            m_mode <= int'(mode_code);
            m_live <= 1'b0;
        end else begin
            m_live <= 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (mode=%0d)", tag, act, exp, m_mode);
        end
    endtask

    // Expected bus values from the requirements.
    task automatic model(output logic [15:0] eo, output logic [15:0] eoe,
                         output logic [3:0] erx, output logic [3:0] etx);
        eo = '0; eoe = '0; erx = '0; etx = '0;
        if (m_live) begin
            if (m_mode == 2) begin
                for (int l = 0; l < 16; l++) begin
                    eoe[l] = 1'b1;
                    if (l < 10)      eo[l] = periph_irq[l];
                    else if (l < 14) eo[l] = ctrl_irq[l-10];
                    else             eo[l] = periph_irq[l-4];
                end
            end else if (m_mode == 0 || m_mode == 4) begin
                eoe[8] = 1'b1; eo[8] = !ctrl_irq[0];
                eoe[9] = 1'b1; eo[9] = !ctrl_irq[2];
                if (m_mode == 4) begin
                    eoe[12] = 1'b1; eo[12] = !ctrl_irq[1];
                    eoe[13] = 1'b1; eo[13] = !ctrl_irq[3];
                end
                erx = tile_in[3:0];
                etx = tile_in[7:4];
            end
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        logic [15:0] eo, eoe;
        logic [3:0]  erx, etx;
        logic [15:0] msk;
        if (armed && !done) begin
            model(eo, eoe, erx, etx);
            if (!m_live) begin
                chk("R2", {tile_out, tile_oe, comm_rx, comm_tx}, {eo, eoe, erx, etx});
            end else if (int'(mode_code) != m_mode) begin
                chk("R1", {tile_out, tile_oe, comm_rx, comm_tx}, {eo, eoe, erx, etx});
            end else if (m_mode == 2) begin
                chk("R3", {tile_out, tile_oe, comm_rx, comm_tx}, {eo, eoe, erx, etx});
            end else if (m_mode == 0 || m_mode == 4) begin
                chk("R4", {36'd0, tile_out[9:8], tile_oe[9:8]}, {36'd0, eo[9:8], eoe[9:8]});
                chk("R5", {36'd0, tile_out[13:12], tile_oe[13:12]}, {36'd0, eo[13:12], eoe[13:12]});
                msk = 16'hCCFF;
                chk("R6", {8'd0, tile_out & msk, tile_oe & msk}, 40'd0);
                chk("R7", {32'd0, comm_rx, comm_tx}, {32'd0, erx, etx});
            end else begin
                chk("R8", {tile_out, tile_oe, comm_rx, comm_tx}, 40'd0);
            end
            chk("R9", {24'd0, tile_out & ~tile_oe}, 40'd0);
        end
    end

    task automatic stir();
        periph_irq = 12'($urandom);
        ctrl_irq   = 4'($urandom);
        tile_in    = 8'($urandom);
    endtask

    task automatic do_reset(input logic [2:0] code);
        @(posedge clk); #1;
        rst_n = 1'b0; mode_code = code; stir();
        repeat (3) begin @(posedge clk); #1; stir(); end
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; stir();
        end
    endtask

    initial begin
        do_reset(3'b010); run(40);
        mode_code = 3'b000; run(20);          // R1: change while live
        do_reset(3'b000); run(40);
        mode_code = 3'b100; run(10);          // R1: FIQ bit ignored while live
        do_reset(3'b100); run(40);
        mode_code = 3'b111; run(10);
        for (int c = 0; c < 8; c++) begin
            if (c != 0 && c != 2 && c != 4) begin
                do_reset(3'(c)); run(25);     // R8 codes
            end
        end
        ctrl_irq = 4'b0000;
        do_reset(3'b100); run(5);
        @(posedge clk); #1; ctrl_irq = 4'b1111; periph_irq = '0;
        @(negedge clk);
        @(posedge clk); #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule